// File: doc/BRIEF.md
# Memory-Mapped Data Memory Decoder

This block is the data memory of a 16-bit machine. To the processor it is one RAM-like port: an address, a write word, a load strobe and a read word. Behind that port a single flat address space is split three ways: general-purpose word storage, a pixel buffer that the processor can both write and read back, and one read-only word that carries the code of the key currently held down. Reads are combinational; writes commit on the rising clock edge.

The pixel buffer has a second, independent read port so that display scan logic can fetch any buffer word at any time without disturbing processor traffic. The key word is driven straight from an external key-code input. Region sizes are parameters: the general store spans `2**RAM_AW` words from address 0, the pixel buffer `2**SCR_AW` words directly above it, the key word sits at the next address, and every address beyond it is unmapped. With `RAM_AW=14`, `SCR_AW=13` and `ADDR_W=15` this gives general storage at 0x0000-0x3FFF, the pixel buffer at 0x4000-0x5FFF and the key word at 0x6000.

Top module: `mm_data_mem`

## Requirements
- R1: `rdata` follows `addr` combinationally; when `addr` is below `2**RAM_AW`, it shows the general-store word at that address with no clock edge needed.
- R2: With `load`=1 at a rising edge, `wdata` is stored at `addr` and is readable from that edge on; with `load`=0 nothing is stored.
- R3: Addresses from `2**RAM_AW` to `2**RAM_AW + 2**SCR_AW - 1` form the pixel buffer; a word written there reads back through `rdata` at the same address.
- R4: `scan_data` shows, combinationally, the pixel-buffer word at offset `scan_addr` (buffer address minus `2**RAM_AW`), whatever `addr` and `load` are doing.
- R5: At address `2**RAM_AW + 2**SCR_AW`, `rdata` equals `key_code` (0 meaning no key is held).
- R6: A write to the key-word address changes no stored word, and the key word still reads `key_code`.
- R7: Any address above the key word reads 0, and a write there changes no stored word.
- R8: A write changes only the region selected by the address: a general-store write leaves the pixel buffer unchanged and a pixel-buffer write leaves the general store unchanged, even at equal low address bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| addr | input | ADDR_W | Processor word address |
| wdata | input | DATA_W | Word to store |
| load | input | 1 | Write strobe, sampled at the rising edge |
| rdata | output | DATA_W | Word at `addr` (combinational) |
| scan_addr | input | SCR_AW | Display-side pixel-buffer offset |
| scan_data | output | DATA_W | Pixel-buffer word at `scan_addr` (combinational) |
| key_code | input | DATA_W | Code of the held key, 0 when none |

## Verification
The bench builds the block with `ADDR_W=8`, `RAM_AW=6` and `SCR_AW=5`, so the general store is addresses 0-63, the pixel buffer 64-95, the key word 96 and everything from 97 to 255 is unmapped. At that size every region edge is reachable in a handful of writes, and the key-word and unmapped addresses share low bits with real storage words (96 with general word 32 and buffer word 0, 128 with both word 0s, 200 with general word 8), so a decoder that forgot the upper bits would visibly corrupt those words.

// File: rtl/mm_data_mem_pkg.sv
package mm_data_mem_pkg;

   typedef enum logic [1:0] {
      RGN_GEN  = 2'd0,
      RGN_PIX  = 2'd1,
      RGN_KEY  = 2'd2,
      RGN_NONE = 2'd3
   } region_e;

endpackage

// File: rtl/mm_addr_decode.sv
module mm_addr_decode
   import mm_data_mem_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int RAM_AW = 9,
   parameter int SCR_AW = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [RAM_AW-1:0] gen_off,
   output logic [SCR_AW-1:0] pix_off
);

   localparam int GEN_WORDS = 1 << RAM_AW;
   localparam int PIX_WORDS = 1 << SCR_AW;
   localparam logic [ADDR_W-1:0] PIX_BASE = ADDR_W'(GEN_WORDS);
   localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(GEN_WORDS + PIX_WORDS);

   always_comb begin
      if (addr < PIX_BASE)
         region = RGN_GEN;
      else if (addr < KEY_ADDR)
         region = RGN_PIX;
      else if (addr == KEY_ADDR)
         region = RGN_KEY;
      else
         region = RGN_NONE;
   end

   // The buffer base is a multiple of its size, so the low bits are the offset.
   assign gen_off = addr[RAM_AW-1:0];
   assign pix_off = addr[SCR_AW-1:0];

endmodule

// File: rtl/mm_word_bank.sv
module mm_word_bank #(
   parameter int AW        = 8,
   parameter int DW        = 16,
   parameter bit SCAN_PORT = 1'b0
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [AW-1:0] scan_addr,
   output logic [DW-1:0] scan_data
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         store[addr] <= wdata;
   end

   assign rdata = store[addr];

   generate
      if (SCAN_PORT) begin : g_scan
         assign scan_data = store[scan_addr];
      end else begin : g_no_scan
         logic unused_scan;
         assign unused_scan = ^scan_addr;
         assign scan_data   = '0;
      end
   endgenerate

endmodule

// File: rtl/mm_data_mem.sv
module mm_data_mem
   import mm_data_mem_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 16,
   parameter int RAM_AW = 9,
   parameter int SCR_AW = 8
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              load,
   output logic [DATA_W-1:0] rdata,
   input  logic [SCR_AW-1:0] scan_addr,
   output logic [DATA_W-1:0] scan_data,
   input  logic [DATA_W-1:0] key_code
);

   generate
      if (SCR_AW >= RAM_AW) begin : g_bad_split
         $error("mm_data_mem: SCR_AW must be smaller than RAM_AW");
      end
      if (ADDR_W <= RAM_AW) begin : g_bad_addr
         $error("mm_data_mem: ADDR_W must exceed RAM_AW to reach the buffer and key word");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mm_data_mem: DATA_W must be positive");
      end
   endgenerate

   region_e           region;
   logic [RAM_AW-1:0] gen_off;
   logic [SCR_AW-1:0] pix_off;
   logic [DATA_W-1:0] gen_rd;
   logic [DATA_W-1:0] pix_rd;
   logic [DATA_W-1:0] gen_scan_unused;
   logic              gen_we;
   logic              pix_we;

   mm_addr_decode #(
      .ADDR_W(ADDR_W),
      .RAM_AW(RAM_AW),
      .SCR_AW(SCR_AW)
   ) u_dec (
      .addr   (addr),
      .region (region),
      .gen_off(gen_off),
      .pix_off(pix_off)
   );

   assign gen_we = load && (region == RGN_GEN);
   assign pix_we = load && (region == RGN_PIX);

   mm_word_bank #(
      .AW       (RAM_AW),
      .DW       (DATA_W),
      .SCAN_PORT(1'b0)
   ) u_gen (
      .clk      (clk),
      .we       (gen_we),
      .addr     (gen_off),
      .wdata    (wdata),
      .rdata    (gen_rd),
      .scan_addr('0),
      .scan_data(gen_scan_unused)
   );

   mm_word_bank #(
      .AW       (SCR_AW),
      .DW       (DATA_W),
      .SCAN_PORT(1'b1)
   ) u_pix (
      .clk      (clk),
      .we       (pix_we),
      .addr     (pix_off),
      .wdata    (wdata),
      .rdata    (pix_rd),
      .scan_addr(scan_addr),
      .scan_data(scan_data)
   );

   always_comb begin
      unique case (region)
         RGN_GEN:  rdata = gen_rd;
         RGN_PIX:  rdata = pix_rd;
         RGN_KEY:  rdata = key_code;
         default:  rdata = '0;
      endcase
   end

   logic unused_ok;
   assign unused_ok = ^gen_scan_unused;

endmodule

// File: rtl/mm_data_mem_chk.sv
module mm_data_mem_chk #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 16,
   parameter int RAM_AW = 9,
   parameter int SCR_AW = 8
) (
   input logic              clk,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              load,
   input logic [DATA_W-1:0] rdata,
   input logic [SCR_AW-1:0] scan_addr,
   input logic [DATA_W-1:0] scan_data,
   input logic [DATA_W-1:0] key_code
);

   localparam logic [ADDR_W-1:0] PIX_LO = ADDR_W'(1 << RAM_AW);
   localparam logic [ADDR_W-1:0] KEY_AT = ADDR_W'((1 << RAM_AW) + (1 << SCR_AW));

   logic started = 1'b0;
   always_ff @(posedge clk) started <= 1'b1;

   logic in_gen, in_pix;
   logic [ADDR_W-1:0] pix_rel;
   assign in_gen  = addr < PIX_LO;
   assign in_pix  = (addr >= PIX_LO) && (addr < KEY_AT);
   assign pix_rel = addr - PIX_LO;

   // R2 - a stored general word reads back on the following cycle
   assert_gen_write_R2: assert property (@(posedge clk) disable iff (!started)
      (load && in_gen) |=> ((addr != $past(addr)) || (rdata == $past(wdata))));

   // R3 - a stored buffer word reads back through the processor port
   assert_pix_write_R3: assert property (@(posedge clk) disable iff (!started)
      (load && in_pix) |=> ((addr != $past(addr)) || (rdata == $past(wdata))));

   // R4 - the scan port sees the same buffer word the processor port sees
   assert_scan_match_R4: assert property (@(posedge clk) disable iff (!started)
      (in_pix && (pix_rel[SCR_AW-1:0] == scan_addr)) |-> (rdata == scan_data));

   // R5 - the key word reflects the key-code input
   assert_key_word_R5: assert property (@(posedge clk) disable iff (!started)
      (addr == KEY_AT) |-> (rdata == key_code));

   // R7 - unmapped addresses read zero
   assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!started)
      (addr > KEY_AT) |-> (rdata == '0));

   // R8 - a general-store write leaves the scanned buffer word alone
   assert_gen_spares_pix_R8: assert property (@(posedge clk) disable iff (!started)
      (load && !in_pix && $stable(scan_addr)) |=>
         ((scan_addr != $past(scan_addr)) || (scan_data == $past(scan_data))));

endmodule

bind mm_data_mem mm_data_mem_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .RAM_AW(RAM_AW),
   .SCR_AW(SCR_AW)
) u_chk (
   .clk      (clk),
   .addr     (addr),
   .wdata    (wdata),
   .load     (load),
   .rdata    (rdata),
   .scan_addr(scan_addr),
   .scan_data(scan_data),
   .key_code (key_code)
);

// File: tb/tb_mm_data_mem.sv
module tb_mm_data_mem;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 16;
   localparam int RAM_AW = 6;
   localparam int SCR_AW = 5;
   localparam int PIX_LO = 64;
   localparam int KEY_AT = 96;

   logic              clk = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic              load = 1'b0;
   logic [DATA_W-1:0] rdata;
   logic [SCR_AW-1:0] scan_addr = '0;
   logic [DATA_W-1:0] scan_data;
   logic [DATA_W-1:0] key_code = '0;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mm_data_mem #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .RAM_AW(RAM_AW),
      .SCR_AW(SCR_AW)
   ) dut (
      .clk      (clk),
      .addr     (addr),
      .wdata    (wdata),
      .load     (load),
      .rdata    (rdata),
      .scan_addr(scan_addr),
      .scan_data(scan_data),
      .key_code (key_code)
   );

   task automatic check(input string req, input logic [DATA_W-1:0] got,
                        input logic [DATA_W-1:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
      end
   endtask

   // Drive on the falling edge, commit at the next rising edge.
   task automatic write_word(input int a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      addr  = ADDR_W'(a);
      wdata = d;
      load  = 1'b1;
      @(posedge clk);
      #1;
      load  = 1'b0;
   endtask

   task automatic idle_edge(input int a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      addr  = ADDR_W'(a);
      wdata = d;
      load  = 1'b0;
      @(posedge clk);
      #1;
   endtask

   task automatic read_cpu(input int a, output logic [DATA_W-1:0] v);
      addr = ADDR_W'(a);
      #1;
      v = rdata;
   endtask

   task automatic read_scan(input int off, output logic [DATA_W-1:0] v);
      scan_addr = SCR_AW'(off);
      #1;
      v = scan_data;
   endtask

   task automatic t_idle_state;
      logic [DATA_W-1:0] v;
      read_cpu(KEY_AT, v);
      check("R5 key word with no key", v, 16'h0000);
      read_cpu(KEY_AT + 1, v);
      check("R7 first unmapped word", v, 16'h0000);
   endtask

   task automatic t_gen_store;
      logic [DATA_W-1:0] v;
      write_word(0, 16'hA5A5);
      write_word(63, 16'h5A5A);
      write_word(17, 16'h0F0F);
      read_cpu(0, v);   check("R2 general word 0", v, 16'hA5A5);
      read_cpu(63, v);  check("R1 top general word", v, 16'h5A5A);
      read_cpu(17, v);  check("R1 mid general word", v, 16'h0F0F);
      read_cpu(0, v);   check("R1 address change without clock", v, 16'hA5A5);
      idle_edge(17, 16'hFFFF);
      read_cpu(17, v);  check("R2 no store when load low", v, 16'h0F0F);
   endtask

   task automatic t_pix_store;
      logic [DATA_W-1:0] v;
      write_word(PIX_LO, 16'h1111);
      write_word(PIX_LO + 31, 16'h8001);
      read_cpu(PIX_LO, v);       check("R3 buffer first word", v, 16'h1111);
      read_cpu(PIX_LO + 31, v);  check("R3 buffer last word", v, 16'h8001);
      addr = ADDR_W'(5);
      read_scan(0, v);           check("R4 scan offset 0", v, 16'h1111);
      read_scan(31, v);          check("R4 scan offset 31", v, 16'h8001);
      // Scan stays readable while the processor writes elsewhere.
      write_word(PIX_LO + 7, 16'h7777);
      read_scan(31, v);          check("R4 scan during write", v, 16'h8001);
      read_scan(7, v);           check("R4 scan sees new word", v, 16'h7777);
   endtask

   task automatic t_isolation;
      logic [DATA_W-1:0] v;
      write_word(3, 16'hCAFE);
      write_word(PIX_LO + 3, 16'hBEEF);
      read_cpu(3, v);  check("R8 general word kept after buffer write", v, 16'hCAFE);
      read_scan(3, v); check("R8 buffer word", v, 16'hBEEF);
      write_word(3, 16'hD00D);
      read_scan(3, v); check("R8 buffer kept after general write", v, 16'hBEEF);
   endtask

   task automatic t_key_word;
      logic [DATA_W-1:0] v;
      write_word(32, 16'h3232);
      write_word(PIX_LO, 16'h4040);
      key_code = 16'h0041;
      read_cpu(KEY_AT, v);  check("R5 key code shown", v, 16'h0041);
      key_code = 16'h0084;
      read_cpu(KEY_AT, v);  check("R5 key code follows input", v, 16'h0084);
      write_word(KEY_AT, 16'hDEAD);
      read_cpu(KEY_AT, v);  check("R6 key word not written", v, 16'h0084);
      read_cpu(32, v);      check("R6 general word 32 untouched", v, 16'h3232);
      read_scan(0, v);      check("R6 buffer word 0 untouched", v, 16'h4040);
      key_code = 16'h0000;
      read_cpu(KEY_AT, v);  check("R5 key released", v, 16'h0000);
   endtask

   task automatic t_unmapped;
      logic [DATA_W-1:0] v;
      write_word(0, 16'h0101);
      write_word(8, 16'h0808);
      write_word(PIX_LO, 16'h6464);
      write_word(128, 16'hBAD1);
      write_word(200, 16'hBAD2);
      write_word(255, 16'hBAD3);
      read_cpu(128, v);  check("R7 address 128 reads zero", v, 16'h0000);
      read_cpu(255, v);  check("R7 address 255 reads zero", v, 16'h0000);
      read_cpu(0, v);    check("R7 general word 0 untouched", v, 16'h0101);
      read_cpu(8, v);    check("R7 general word 8 untouched", v, 16'h0808);
      read_scan(0, v);   check("R7 buffer word 0 untouched", v, 16'h6464);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      #1;
      t_idle_state();
      t_gen_store();
      t_pix_store();
      t_isolation();
      t_key_word();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule